// File: doc/BRIEF.md
# Pattern and PRBS Output Formatter

This block produces one data line and one strobe line for a pulse or pattern source. The data bits come either from a loadable bit memory or from a pseudo-random generator whose register length can be set from 7 to 12. The strobe bits always come from a second loadable bit memory. One bit is issued per output period. The period is marked by a half-period enable, `half_en`, that the period logic pulses twice per bit. Each data bit is shaped into non-return-to-zero, return-to-zero or half-period-delayed non-return-to-zero form. The strobe is always issued in plain non-return-to-zero form.

Trigger logic upstream decides when patterns are played. A `start` pulse arms a run, which begins at address 0 on the next half-period tick. The configured last address ends a pass. The pass then either ends the run or wraps back to address 0. It wraps only when wrapping is configured and the `gate` input is high at the end of the pass. A continuous mode holds `gate` high. A single-shot trigger leaves wrapping off. A gated mode drops `gate`, and the pass in progress is still completed.

Top module: `pat_fmt_top`

## Requirements
- R1: While reset is high, and on every idle tick after it, `data_out` and `strobe_out` are 0.
- R2: With `cfg_fmt` = 0 (NRZ), or the unused code 3, each data bit drives `data_out` for both half-periods of its bit period. A run plays memory bits from address 0 upward. The first half-period output appears on the first `half_en` tick after the `start` pulse.
- R3: With `cfg_fmt` = 1 (RZ), a 1 bit drives `data_out` high in the first half-period and low in the second. A 0 bit drives it low for both halves.
- R4: With `cfg_fmt` = 2 (delayed NRZ), the first half-period shows the previous bit of the run, which is 0 for the first bit of a run. The second half-period shows the current bit. The previous bit carries across a wrap.
- R5: `strobe_out` shows the strobe memory bit at the same address for both half-periods, whatever the data format. `wr_strobe` = 1 writes the strobe memory and 0 writes the data memory.
- R6: With wrapping off, the run stops after the second half-period of the bit at `cfg_last`. The next tick drives both outputs to 0. A later `start` replays from address 0.
- R7: With wrapping on, the run continues at address 0 after the last address if `gate` is high at the end of the pass. If `gate` is low at that point, the run stops there, and the pass in progress is always completed.
- R8: A `start` pulse during a run has no effect on the outputs.
- R9: With `cfg_src` = 1, the data bits follow a maximal-length sequence of period 2^n-1 that contains 2^(n-1) ones per period, for n = 7 to 12.
- R10: Reset or a configuration write seeds the generator with all ones, so the first n random bits are 1 and bit n+1 is 0. A configuration write also ends any run, and outputs are 0 on the next tick.
- R11: An order code outside 7..12 is treated as order 7.
- R12: Both outputs change only on clock edges where `half_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_en | input | 1 | Half-period tick; two ticks form one bit period |
| wr_en | input | 1 | Memory write strobe |
| wr_strobe | input | 1 | 1 selects strobe memory, 0 data memory |
| wr_addr | input | AW | Memory write address |
| wr_bit | input | 1 | Memory write data |
| cfg_we | input | 1 | Configuration write; reseeds generator and ends run |
| cfg_src | input | 1 | 0 memory, 1 pseudo-random |
| cfg_fmt | input | 2 | 0 NRZ, 1 RZ, 2 delayed NRZ |
| cfg_order | input | 4 | Generator register length |
| cfg_last | input | AW | Last address of a pass |
| cfg_wrap | input | 1 | Allow wrap at the end of a pass |
| start | input | 1 | Arms a run while idle |
| gate | input | 1 | Continue past the end of a pass when wrapping |
| data_out | output | 1 | Shaped data line |
| strobe_out | output | 1 | Strobe line |

## Verification
A generator that collapses to the all-zero state holds `data_out` low forever, which is visible within n+1 bits of a seed. A generator with wrong taps shows up as a wrong ones count or a broken repeat within two periods. A phase register that is off by one swaps the two halves of an RZ or delayed NRZ bit, which is visible on the first 1 bit of a run. An address or end-of-pass error appears at the first pass boundary as a repeated, skipped or missing bit. A stale previous-bit register shows in the first half-period after a start or a wrap.

// File: rtl/pat_fmt_pkg.sv
package pat_fmt_pkg;

    localparam int PRBS_W = 12;

    typedef enum logic {
        SRC_MEM  = 1'b0,
        SRC_PRBS = 1'b1
    } src_e;

    typedef enum logic [1:0] {
        FMT_NRZ  = 2'd0,
        FMT_RZ   = 2'd1,
        FMT_DNRZ = 2'd2,
        FMT_RSVD = 2'd3
    } fmt_e;

    typedef struct packed {
        src_e       src;
        fmt_e       fmt;
        logic [3:0] order;
        logic       wrap;
    } cfg_t;

    // Clamp an order code to the supported range.
    function automatic logic [3:0] eff_order(input logic [3:0] o);
        return (o < 4'd7 || o > 4'd12) ? 4'd7 : o;
    endfunction

    // Ones in the low o bits.
    function automatic logic [PRBS_W-1:0] order_mask(input logic [3:0] o);
        logic [PRBS_W:0] one_hot;
        one_hot = (PRBS_W+1)'(1) << o;
        return PRBS_W'(one_hot - 1'b1);
    endfunction

    // Feedback taps, bit (e-1) set for each exponent e of the polynomial.
    function automatic logic [PRBS_W-1:0] tap_mask(input logic [3:0] o);
        case (o)
            4'd8:    return 12'h0B8;
            4'd9:    return 12'h110;
            4'd10:   return 12'h240;
            4'd11:   return 12'h500;
            4'd12:   return 12'h829;
            default: return 12'h060;
        endcase
    endfunction

endpackage

// File: rtl/pat_bitmem.sv
module pat_bitmem #(
    parameter int DEPTH = 4096,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata,
    input  logic [AW-1:0] raddr,
    output logic          rdata
);
    logic [DEPTH-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst)
            bits_q <= '0;
        else if (we)
            bits_q[waddr] <= wdata;
    end

    assign rdata = bits_q[raddr];
endmodule

// File: rtl/pat_prbs.sv
module pat_prbs
    import pat_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              seed,
    input  logic              step,
    input  logic [3:0]        order,
    output logic              bit_o,
    output logic [PRBS_W-1:0] state_o
);
    logic [PRBS_W-1:0] st_q;
    logic [PRBS_W-1:0] shifted;
    logic [3:0]        top_idx;
    logic              fb;

    assign fb      = ^(st_q & tap_mask(order));
    assign top_idx = order - 4'd1;
    assign shifted = st_q >> top_idx;
    assign bit_o   = shifted[0];
    assign state_o = st_q;

    always_ff @(posedge clk) begin
        if (rst || seed)
            st_q <= '1;
        else if (step)
            st_q <= {st_q[PRBS_W-2:0], fb} & order_mask(order);
    end
endmodule

// File: rtl/pat_shaper.sv
module pat_shaper
    import pat_fmt_pkg::*;
(
    input  fmt_e fmt,
    input  logic second_half,
    input  logic cur,
    input  logic prev,
    output logic lvl
);
    always_comb begin
        case (fmt)
            FMT_RZ:   lvl = second_half ? 1'b0 : cur;
            FMT_DNRZ: lvl = second_half ? cur : prev;
            default:  lvl = cur;
        endcase
    end
endmodule

// File: rtl/pat_fmt_top.sv
module pat_fmt_top
    import pat_fmt_pkg::*;
#(
    parameter int DEPTH = 4096,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          half_en,
    input  logic          wr_en,
    input  logic          wr_strobe,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic          cfg_we,
    input  logic          cfg_src,
    input  logic [1:0]    cfg_fmt,
    input  logic [3:0]    cfg_order,
    input  logic [AW-1:0] cfg_last,
    input  logic          cfg_wrap,
    input  logic          start,
    input  logic          gate,
    output logic          data_out,
    output logic          strobe_out
);
    cfg_t          cfg_q;
    logic [AW-1:0] last_q;
    logic          running_q, armed_q, phase_q;
    logic [AW-1:0] addr_q;
    logic          cur_q, strb_bit_q, prev_q;
    logic          data_q, strb_q;

    logic              mem_data_bit, mem_strb_bit;
    logic              prbs_bit;
    logic [PRBS_W-1:0] prbs_state;
    logic [PRBS_W-1:0] live_mask;
    logic              active, src_bit, shaped, shape_cur, at_end;

    assign active    = running_q || armed_q;
    assign src_bit   = (cfg_q.src == SRC_PRBS) ? prbs_bit : mem_data_bit;
    assign shape_cur = phase_q ? cur_q : src_bit;
    assign at_end    = (addr_q == last_q);
    assign live_mask = order_mask(cfg_q.order);

    pat_bitmem #(.DEPTH(DEPTH)) u_data_mem (
        .clk(clk), .rst(rst), .we(wr_en && !wr_strobe), .waddr(wr_addr),
        .wdata(wr_bit), .raddr(addr_q), .rdata(mem_data_bit)
    );

    pat_bitmem #(.DEPTH(DEPTH)) u_strb_mem (
        .clk(clk), .rst(rst), .we(wr_en && wr_strobe), .waddr(wr_addr),
        .wdata(wr_bit), .raddr(addr_q), .rdata(mem_strb_bit)
    );

    pat_prbs u_prbs (
        .clk(clk), .rst(rst), .seed(cfg_we),
        .step(half_en && active && !phase_q && !cfg_we && cfg_q.src == SRC_PRBS),
        .order(cfg_q.order), .bit_o(prbs_bit), .state_o(prbs_state)
    );

    pat_shaper u_shape (
        .fmt(cfg_q.fmt), .second_half(phase_q), .cur(shape_cur),
        .prev(prev_q), .lvl(shaped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '{src: SRC_MEM, fmt: FMT_NRZ, order: 4'd7, wrap: 1'b0};
            last_q     <= AW'(DEPTH - 1);
            running_q  <= 1'b0;
            armed_q    <= 1'b0;
            phase_q    <= 1'b0;
            addr_q     <= '0;
            cur_q      <= 1'b0;
            strb_bit_q <= 1'b0;
            prev_q     <= 1'b0;
            data_q     <= 1'b0;
            strb_q     <= 1'b0;
        end else if (cfg_we) begin
            cfg_q     <= '{src: src_e'(cfg_src), fmt: fmt_e'(cfg_fmt),
                           order: eff_order(cfg_order), wrap: cfg_wrap};
            last_q    <= cfg_last;
            running_q <= 1'b0;
            armed_q   <= 1'b0;
            phase_q   <= 1'b0;
            addr_q    <= '0;
            prev_q    <= 1'b0;
        end else begin
            if (start && !running_q)
                armed_q <= 1'b1;
            if (half_en) begin
                if (active) begin
                    armed_q   <= 1'b0;
                    running_q <= 1'b1;
                    data_q    <= shaped;
                    if (!phase_q) begin
                        cur_q      <= src_bit;
                        strb_bit_q <= mem_strb_bit;
                        strb_q     <= mem_strb_bit;
                        phase_q    <= 1'b1;
                    end else begin
                        strb_q  <= strb_bit_q;
                        prev_q  <= cur_q;
                        phase_q <= 1'b0;
                        if (!at_end) begin
                            addr_q <= addr_q + 1'b1;
                        end else begin
                            addr_q <= '0;
                            if (!(cfg_q.wrap && gate)) begin
                                running_q <= 1'b0;
                                prev_q    <= 1'b0;
                            end
                        end
                    end
                end else begin
                    data_q <= 1'b0;
                    strb_q <= 1'b0;
                end
            end
        end
    end

    assign data_out   = data_q;
    assign strobe_out = strb_q;
endmodule

// File: rtl/pat_fmt_chk.sv
module pat_fmt_chk
    import pat_fmt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              half_en,
    input logic              cfg_we,
    input fmt_e              fmt,
    input logic              phase,
    input logic              running,
    input logic              armed,
    input logic [PRBS_W-1:0] prbs_state,
    input logic [PRBS_W-1:0] live_mask,
    input logic              data_out,
    input logic              strobe_out
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!data_out && !strobe_out));

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!running && !armed && half_en && !cfg_we) |=> (!data_out && !strobe_out));

    a_r3_rz_second_half_low: assert property (@(posedge clk) disable iff (rst)
        (fmt == FMT_RZ && half_en && phase && !cfg_we) |=> !data_out);

    a_r12_data_hold: assert property (@(posedge clk) disable iff (rst)
        !half_en |=> $stable(data_out));

    a_r12_strobe_hold: assert property (@(posedge clk) disable iff (rst)
        !half_en |=> $stable(strobe_out));

    a_r10_prbs_never_zero: assert property (@(posedge clk) disable iff (rst)
        (prbs_state & live_mask) != '0);
endmodule

bind pat_fmt_top pat_fmt_chk u_chk (
    .clk(clk), .rst(rst), .half_en(half_en), .cfg_we(cfg_we),
    .fmt(cfg_q.fmt), .phase(phase_q), .running(running_q), .armed(armed_q),
    .prbs_state(prbs_state), .live_mask(live_mask),
    .data_out(data_out), .strobe_out(strobe_out)
);

// File: tb/pat_fmt_top_test.sv
module pat_fmt_top_test;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          half_en = 1'b0;
    logic          wr_en = 1'b0, wr_strobe = 1'b0, wr_bit = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          cfg_we = 1'b0, cfg_src = 1'b0, cfg_wrap = 1'b0;
    logic [1:0]    cfg_fmt = 2'd0;
    logic [3:0]    cfg_order = 4'd7;
    logic [AW-1:0] cfg_last = '0;
    logic          start = 1'b0, gate = 1'b1;
    logic          data_out, strobe_out;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [15:0] dpat = 16'b1011_0100_1101_0011;
    logic [15:0] spat = 16'b0101_1010_0001_1100;
    logic        seq [0:8191];

    always #2 clk = ~clk;

    pat_fmt_top uut (
        .clk(clk), .rst(rst), .half_en(half_en), .wr_en(wr_en),
        .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_bit(wr_bit),
        .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_fmt(cfg_fmt),
        .cfg_order(cfg_order), .cfg_last(cfg_last), .cfg_wrap(cfg_wrap),
        .start(start), .gate(gate), .data_out(data_out), .strobe_out(strobe_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) half_en = 1'b1;
        @(negedge clk) half_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic write_cfg(input logic src, input logic [1:0] fmt,
                             input logic [3:0] ord, input int last, input logic wrap);
        @(negedge clk);
        cfg_we = 1'b1; cfg_src = src; cfg_fmt = fmt; cfg_order = ord;
        cfg_last = AW'(last); cfg_wrap = wrap;
        @(negedge clk) cfg_we = 1'b0;
    endtask

    task automatic write_mem(input logic sel, input int addr, input logic b);
        @(negedge clk);
        wr_en = 1'b1; wr_strobe = sel; wr_addr = AW'(addr); wr_bit = b;
        @(negedge clk) wr_en = 1'b0;
    endtask

    function automatic logic shape(input int fmt, input int half, input logic cur, input logic prev);
        if (fmt == 1) return (half == 1) ? 1'b0 : cur;
        if (fmt == 2) return (half == 1) ? cur : prev;
        return cur;
    endfunction

    function automatic string fmt_tag(input int fmt);
        if (fmt == 1) return "R3";
        if (fmt == 2) return "R4";
        return "R2";
    endfunction

    // Plays nbits bits of a memory pattern of length L and checks every half-period.
    task automatic run_pattern(input int fmt, input int L, input int nbits,
                               input int gate_low_at, input bit mid_start, input int gap);
        logic  prev, b, s;
        string tag;
        write_cfg(1'b0, 2'(fmt), 4'd7, L - 1, nbits > L);
        gate = 1'b1;
        pulse_start();
        prev = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            if (i == gate_low_at) gate = 1'b0;
            if (mid_start && i == 1) pulse_start();
            b = dpat[i % L];
            s = spat[i % L];
            tag = mid_start ? "R8" : (nbits > L ? "R7" : fmt_tag(fmt));
            for (int h = 0; h < 2; h++) begin
                tick();
                chk(tag, data_out, shape(fmt, h, b, prev));
                chk("R5", strobe_out, s);
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    chk("R12", data_out, shape(fmt, h, b, prev));
                    chk("R12", strobe_out, s);
                end
            end
            prev = b;
        end
        tick();
        chk(nbits > L ? "R7 stop" : "R6 stop", data_out, 1'b0);
        chk("R6 stop strobe", strobe_out, 1'b0);
        gate = 1'b1;
    endtask

    // Collects 2P random bits and checks seed, ones count and repetition.
    task automatic prbs_test(input logic [3:0] ord, input int n, input string seed_tag);
        int p, ones, mism, lead;
        p = (1 << n) - 1;
        write_cfg(1'b1, 2'd0, ord, 4095, 1'b1);
        gate = 1'b1;
        pulse_start();
        for (int i = 0; i < 2 * p; i++) begin
            tick();
            tick();
            seq[i] = data_out;
        end
        lead = 0;
        for (int i = 0; i < n; i++) if (seq[i] == 1'b1) lead++;
        chk_int(seed_tag, lead, n);
        chk(seed_tag, seq[n], 1'b0);
        ones = 0;
        for (int i = 0; i < p; i++) if (seq[i] == 1'b1) ones++;
        chk_int("R9 ones per period", ones, 1 << (n - 1));
        mism = 0;
        for (int i = 0; i < p; i++) if (seq[i] !== seq[i + p]) mism++;
        chk_int("R9 repeat", mism, 0);
        write_cfg(1'b0, 2'd0, 4'd7, 15, 1'b0);
        tick();
        chk("R10 cfg ends run", data_out, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset data", data_out, 1'b0);
        chk("R1 reset strobe", strobe_out, 1'b0);
        rst = 1'b0;
        tick();
        tick();
        chk("R1 idle data", data_out, 1'b0);
        chk("R1 idle strobe", strobe_out, 1'b0);

        for (int k = 0; k < 16; k++) begin
            write_mem(1'b0, k, dpat[k]);
            write_mem(1'b1, k, spat[k]);
        end

        for (int f = 0; f < 4; f++) begin
            run_pattern(f, 1, 1, -1, 1'b0, 0);
            run_pattern(f, 3, 3, -1, 1'b0, 0);
            run_pattern(f, 16, 16, -1, 1'b0, 0);
        end
        run_pattern(0, 16, 16, -1, 1'b0, 0);
        run_pattern(1, 8, 8, -1, 1'b1, 0);
        run_pattern(0, 5, 15, 11, 1'b0, 0);
        run_pattern(2, 3, 9, 7, 1'b0, 0);
        run_pattern(1, 4, 4, -1, 1'b0, 3);

        for (int n = 7; n <= 12; n++)
            prbs_test(4'(n), n, "R10 seed");
        prbs_test(4'd3, 7, "R11 clamp");
        prbs_test(4'd15, 7, "R11 clamp");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule